// File: doc/BRIEF.md
# Multi-protocol CIC decimator

This block lowers the sample rate of a 16-bit signed stream by an integer ratio chosen at run time from a 2-bit protocol select. It is a five-stage cascaded integrator-comb filter with a differential delay of one. The integrators take a sample on each cycle where the input strobe is high. A ratio counter passes one of every R accepted samples into five comb differencers, which run at the low output rate. The comb result is scaled down by the filter's gain and comes out as an 18-bit word with a one-cycle valid pulse.

Each integrator keeps only the most significant bits of a common worst-case reference width. Later stages drop a few more low-order bits than earlier ones. All integrator and comb arithmetic wraps in two's complement. The combs undo the wrap, so no stage ever needs to saturate. When the select changes, every accumulator, delay and the ratio counter is cleared, so each protocol starts from a clean history.

Top module: `proto_cic_decim`

## Requirements
- R1: The select code picks the ratio R: code 0 gives 20, code 1 gives 12, code 2 gives 40, and code 3 behaves like code 0. Exactly one output pulse is produced for every R accepted samples. The pulse is visible in the cycle after the clock edge that takes the R-th accepted sample.
- R2: Each output is the five-fold cascade of length-R moving sums of the accepted samples, with zero history before the run, arithmetically shifted right by G and then saturated to 18 bits. G is 22 for R=20, 18 for R=12 and 27 for R=40. Because of stage width pruning, the output may differ from the exact floored value by at most 1 LSB.
- R3: For a constant input A, every output from the fifth one onward equals floor(A·R^5/2^G) within 1 LSB. For example, A=10000 at code 0 gives 7629, and A=-20000 at code 1 gives -18985.
- R4: A cycle with the input strobe low changes neither the filter state nor the ratio count.
- R5: A change of the select clears all filter state and the ratio count. The sample presented in the cycle of the change is discarded, and the first new output follows R accepted samples after the change.
- R6: Long runs at full-scale input, where the integrators wrap around their widths, still give correct outputs. At code 2, a constant input of 32767 settles to 24999.
- R7: The output valid is a single-cycle pulse, and the output data holds its last value while the valid is low.
- R8: During reset, the output valid and the output data are both zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| proto_sel | input | 2 | Protocol select that chooses the decimation ratio |
| smp_vld | input | 1 | Input sample strobe |
| smp_dat | input | 16 | Signed input sample |
| dec_vld | output | 1 | Output sample pulse |
| dec_dat | output | 18 | Signed, gain-normalised output sample |

## Verification
An output is due in the cycle after the clock edge that accepts the R-th sample since the last select change. The bench queues the expected value when it drives that sample. It samples the outputs a quarter period after each rising edge, so every pulse pops the oldest queued value, and a pulse that arrives with nothing queued counts as a failure. After each run, two idle cycles let the final registered output appear before the pulse count and the empty queue are checked. The hold behaviour of the data is checked on every cycle without a pulse.

// File: rtl/proto_cic_pkg.sv
package proto_cic_pkg;

   localparam int CIC_STAGES = 5;

   typedef enum logic [1:0] {
      SEL_NARROW = 2'd0,
      SEL_WIDE   = 2'd1,
      SEL_DEEP   = 2'd2,
      SEL_SPARE  = 2'd3
   } proto_e;

   // smallest g with 2^g >= r^n
   function automatic int cic_growth(int r, int n);
      longint p;
      int     g;
      p = 1;
      g = 0;
      for (int i = 0; i < n; i++) p = p * longint'(r);
      while ((longint'(1) << g) < p) g++;
      return g;
   endfunction

   function automatic int cic_max3(int a, int b, int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/cic_rate_ctl.sv
module cic_rate_ctl
   import proto_cic_pkg::*;
#(
   parameter int R_A   = 20,
   parameter int R_B   = 12,
   parameter int R_C   = 40,
   parameter int CNT_W = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       in_vld,
   output logic       clr,
   output proto_e     mode,
   output logic       dump
);

   proto_e           sel_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] rlim;
   logic             wrap;

   assign clr = (proto_e'(sel) != sel_q);
   assign mode = sel_q;

   always_comb begin
      case (sel_q)
         SEL_WIDE: rlim = CNT_W'(R_B - 1);
         SEL_DEEP: rlim = CNT_W'(R_C - 1);
         default:  rlim = CNT_W'(R_A - 1);
      endcase
   end

   assign wrap = (cnt == rlim);
   assign dump = in_vld & ~clr & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SEL_NARROW;
         cnt   <= '0;
      end else begin
         sel_q <= proto_e'(sel);
         if (clr) begin
            cnt <= '0;
         end else if (in_vld) begin
            if (wrap) cnt <= '0;
            else      cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cic_integ_stage.sv
module cic_integ_stage #(
   parameter int REF_W = 43,
   parameter int W     = 43
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [REF_W-1:0] din,
   output logic [REF_W-1:0] dout
);

   localparam int SH = REF_W - W;

   logic [W-1:0] acc;
   logic [W-1:0] acc_nxt;
   logic [W-1:0] din_top;

   assign din_top = din[REF_W-1 -: W];

   generate
      if (SH > 0) begin : g_drop
         logic [SH-1:0] lsb_unused;
         assign lsb_unused = din[SH-1:0];
      end
   endgenerate

   assign acc_nxt = acc + din_top;
   assign dout    = REF_W'(acc_nxt) << SH;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= acc_nxt;
   end

endmodule

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
   parameter int W = 39
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] dly;

   assign dout = din - dly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dly <= '0;
      else if (clr) dly <= '0;
      else if (en)  dly <= din;
   end

endmodule

// File: rtl/cic_out_norm.sv
module cic_out_norm
   import proto_cic_pkg::*;
#(
   parameter int COMB_W = 39,
   parameter int OUT_W  = 18,
   parameter int SH_A   = 18,
   parameter int SH_B   = 14,
   parameter int SH_C   = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  proto_e            mode,
   input  logic [COMB_W-1:0] din,
   output logic              out_vld,
   output logic [OUT_W-1:0]  out_dat
);

   localparam logic signed [COMB_W-1:0] PMAX =
      {{(COMB_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [COMB_W-1:0] NMIN =
      {{(COMB_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic [6:0]               sh_amt;
   logic signed [COMB_W-1:0] shv;
   logic [OUT_W-1:0]         sat;

   always_comb begin
      case (mode)
         SEL_WIDE: sh_amt = 7'(SH_B);
         SEL_DEEP: sh_amt = 7'(SH_C);
         default:  sh_amt = 7'(SH_A);
      endcase
   end

   always_comb begin
      shv = $signed(din) >>> sh_amt;
      if (shv > PMAX)      sat = PMAX[OUT_W-1:0];
      else if (shv < NMIN) sat = NMIN[OUT_W-1:0];
      else                 sat = shv[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_dat <= '0;
      end else begin
         out_vld <= en;
         if (en) out_dat <= sat;
      end
   end

endmodule

// File: rtl/proto_cic_decim.sv
module proto_cic_decim
   import proto_cic_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int OUT_W = 18,
   parameter int R_A   = 20,
   parameter int R_B   = 12,
   parameter int R_C   = 40,
   parameter int INT_W [CIC_STAGES] = '{43, 42, 41, 40, 39}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       proto_sel,
   input  logic             smp_vld,
   input  logic [IN_W-1:0]  smp_dat,
   output logic             dec_vld,
   output logic [OUT_W-1:0] dec_dat
);

   localparam int NSTG   = CIC_STAGES;
   localparam int R_MAX  = cic_max3(R_A, R_B, R_C);
   localparam int CNT_W  = $clog2(R_MAX);
   localparam int G_A    = cic_growth(R_A, NSTG);
   localparam int G_B    = cic_growth(R_B, NSTG);
   localparam int G_C    = cic_growth(R_C, NSTG);
   localparam int G_MAX  = cic_max3(G_A, G_B, G_C);
   localparam int REF_W  = IN_W + G_MAX;
   localparam int COMB_W = INT_W[NSTG-1];
   localparam int D_LAST = REF_W - COMB_W;

   // elaboration-time parameter checks
   generate
      if (R_A < 2 || R_B < 2 || R_C < 2) begin : g_bad_ratio
         $error("decimation ratios must be at least 2");
      end
      if (INT_W[0] > REF_W) begin : g_bad_first
         $error("first integrator wider than reference width");
      end
      for (genvar k = 1; k < NSTG; k++) begin : g_mono
         if (INT_W[k] > INT_W[k-1]) begin : g_bad_order
            $error("integrator widths must not grow along the chain");
         end
      end
      if (cic_max3(-G_A, -G_B, -G_C) + D_LAST > 0) begin : g_bad_shift
         $error("pruning discards more bits than the smallest gain shift");
      end
      if (COMB_W <= OUT_W) begin : g_bad_out
         $error("comb width must exceed output width");
      end
   endgenerate

   logic   clr;
   logic   dump;
   proto_e mode;
   logic   int_en;

   cic_rate_ctl #(
      .R_A(R_A), .R_B(R_B), .R_C(R_C), .CNT_W(CNT_W)
   ) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (proto_sel),
      .in_vld (smp_vld),
      .clr    (clr),
      .mode   (mode),
      .dump   (dump)
   );

   assign int_en = smp_vld & ~clr;

   logic [REF_W-1:0]  ichain [NSTG+1];
   logic [COMB_W-1:0] cchain [NSTG+1];

   assign ichain[0] = {{(REF_W-IN_W){smp_dat[IN_W-1]}}, smp_dat};

   generate
      for (genvar k = 0; k < NSTG; k++) begin : g_int
         cic_integ_stage #(
            .REF_W (REF_W),
            .W     (INT_W[k])
         ) u_int (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .en    (int_en),
            .din   (ichain[k]),
            .dout  (ichain[k+1])
         );
      end

      if (D_LAST > 0) begin : g_tail
         logic [D_LAST-1:0] int_lsb_unused;
         assign int_lsb_unused = ichain[NSTG][D_LAST-1:0];
      end
   endgenerate

   assign cchain[0] = ichain[NSTG][REF_W-1 -: COMB_W];

   generate
      for (genvar k = 0; k < NSTG; k++) begin : g_comb
         cic_comb_stage #(
            .W (COMB_W)
         ) u_comb (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .en    (dump),
            .din   (cchain[k]),
            .dout  (cchain[k+1])
         );
      end
   endgenerate

   cic_out_norm #(
      .COMB_W (COMB_W),
      .OUT_W  (OUT_W),
      .SH_A   (G_A - D_LAST),
      .SH_B   (G_B - D_LAST),
      .SH_C   (G_C - D_LAST)
   ) u_norm (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (dump),
      .mode    (mode),
      .din     (cchain[NSTG]),
      .out_vld (dec_vld),
      .out_dat (dec_dat)
   );

endmodule

// File: rtl/proto_cic_decim_chk.sv
module proto_cic_decim_chk #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       proto_sel,
   input logic             smp_vld,
   input logic [OUT_W-1:0] dec_dat,
   input logic             dec_vld
);

   localparam int LIM = (1 << (IN_W - 1)) + 1;

   // R1: a pulse only follows an accepted sample
   a_r1_pulse_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(smp_vld));

   // R7: pulses last a single cycle
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |=> !dec_vld);

   // R7: data holds while no pulse
   a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld |-> $stable(dec_dat));

   // R5: no output right after a select change
   a_r5_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (proto_sel != $past(proto_sel)) |=> !dec_vld);

   // R2: normalised output never exceeds the input range
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> ((int'($signed(dec_dat)) <= LIM) && (int'($signed(dec_dat)) >= -LIM)));

endmodule

bind proto_cic_decim proto_cic_decim_chk #(
   .IN_W  (IN_W),
   .OUT_W (OUT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .proto_sel (proto_sel),
   .smp_vld   (smp_vld),
   .dec_dat   (dec_dat),
   .dec_vld   (dec_vld)
);

// File: tb/proto_cic_decim_tb_top.sv
module proto_cic_decim_tb_top;

   localparam int NMAX = 1024;

   typedef struct packed {
      logic [1:0]         sel;
      logic               kind;   // 0 constant, 1 pseudo-random
      logic signed [15:0] amp;
      int                 nout;
      int                 expv;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{2'd0, 1'b0,  16'sd10000,  6,   7629},
      '{2'd1, 1'b0, -16'sd20000,  6, -18985},
      '{2'd2, 1'b0,  16'sd32767, 20,  24999},
      '{2'd3, 1'b0, -16'sd32768,  6, -25000},
      '{2'd0, 1'b1,  16'sd0,      8,      0},
      '{2'd1, 1'b1,  16'sd0,     10,      0},
      '{2'd2, 1'b1,  16'sd0,      6,      0}
   };

   logic               clk = 1'b0;
   logic               rst_n;
   logic [1:0]         sel;
   logic               vld;
   logic signed [15:0] dat;
   logic               dec_vld;
   logic [17:0]        dec_dat;

   always #10 clk = ~clk;

   proto_cic_decim dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .proto_sel (sel),
      .smp_vld   (vld),
      .smp_dat   (dat),
      .dec_vld   (dec_vld),
      .dec_dat   (dec_dat)
   );

   int     checks = 0;
   int     errors = 0;
   longint sm [6][NMAX];
   int     nidx = 0;
   int     cur_sel = 0;
   longint expq [$];
   int     outs_run = 0;
   longint last_out = 0;
   longint prev_dat = 0;
   logic [15:0] lfsr = 16'hACE1;
   vec_t   v;

   function automatic int ratio_of(int s);
      if (s == 1) return 12;
      if (s == 2) return 40;
      return 20;
   endfunction

   function automatic int shift_of(int s);
      if (s == 1) return 18;
      if (s == 2) return 27;
      return 22;
   endfunction

   task automatic check(string tag, longint act, longint exp, longint tol);
      checks++;
      if ((act - exp > tol) || (exp - act > tol)) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_push(longint x);
      int r;
      longint pv, od;
      r = ratio_of(cur_sel);
      sm[0][nidx] = x;
      for (int k = 1; k < 6; k++) begin
         pv = (nidx > 0) ? sm[k][nidx-1] : 0;
         od = (nidx >= r) ? sm[k-1][nidx-r] : 0;
         sm[k][nidx] = pv + sm[k-1][nidx] - od;
      end
      if (((nidx + 1) % r) == 0)
         expq.push_back(sm[5][nidx] >>> shift_of(cur_sel));
      nidx++;
   endtask

   task automatic drive(int s, logic sv, logic signed [15:0] d);
      @(negedge clk);
      if (s != cur_sel) begin
         check("R5 nothing pending at select change", expq.size(), 0, 0);
         cur_sel = s;
         nidx = 0;
      end else if (sv) begin
         model_push(longint'(d));
      end
      sel = 2'(s);
      vld = sv;
      dat = d;
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         if (dec_vld) begin
            if (expq.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R1 unexpected pulse actual 1 expected 0");
            end else begin
               check("R2 output value", longint'($signed(dec_dat)), expq.pop_front(), 1);
            end
            outs_run++;
            last_out = longint'($signed(dec_dat));
         end else begin
            check("R7 data held", longint'($signed(dec_dat)), prev_dat, 0);
         end
         prev_dat = longint'($signed(dec_dat));
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      sel = 2'd0;
      vld = 1'b0;
      dat = '0;
      repeat (3) @(negedge clk);
      check("R8 reset valid", longint'(dec_vld), 0, 0);
      check("R8 reset data", longint'($signed(dec_dat)), 0, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table of vectors: R1 R2 R3 R6
      for (int i = 0; i < 7; i++) begin
         v = VECS[i];
         drive(int'(v.sel), 1'b0, '0);
         outs_run = 0;
         lfsr = 16'hACE1 + 16'(i);
         for (int j = 0; j < v.nout * ratio_of(int'(v.sel)); j++) begin
            drive(int'(v.sel), 1'b1, v.kind ? $signed(lfsr) : v.amp);
            step_lfsr();
         end
         drive(int'(v.sel), 1'b0, '0);
         drive(int'(v.sel), 1'b0, '0);
         check("R1 output count", outs_run, v.nout, 0);
         check("R2 all outputs seen", expq.size(), 0, 0);
         if (!v.kind) begin
            if (v.sel == 2'd2) check("R6 wrapped constant", last_out, v.expv, 1);
            else               check("R3 settled constant", last_out, v.expv, 1);
         end
      end

      // R4: idle cycles between samples
      drive(1, 1'b0, '0);
      outs_run = 0;
      for (int j = 0; j < 120; j++) begin
         drive(1, 1'b1, $signed(lfsr));
         step_lfsr();
         drive(1, 1'b0, 16'sh7fff);
      end
      drive(1, 1'b0, '0);
      check("R4 count with gaps", outs_run, 10, 0);
      check("R4 all outputs seen", expq.size(), 0, 0);

      // R5: select change mid-run discards history and the change-cycle sample
      drive(0, 1'b0, '0);
      for (int j = 0; j < 7; j++) begin
         drive(0, 1'b1, 16'sd25000);
      end
      outs_run = 0;
      drive(1, 1'b1, 16'sd30000);
      for (int j = 0; j < 11; j++) begin
         drive(1, 1'b1, $signed(lfsr));
         step_lfsr();
      end
      drive(1, 1'b0, '0);
      drive(1, 1'b0, '0);
      check("R5 no output before R new samples", outs_run, 0, 0);
      drive(1, 1'b1, $signed(lfsr));
      drive(1, 1'b0, '0);
      drive(1, 1'b0, '0);
      check("R5 first output after R new samples", outs_run, 1, 0);
      check("R5 output consumed", expq.size(), 0, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule